// File: doc/BRIEF.md
# Core Thread Run-Control Register Block

This block gives a host a small 64-bit register window for controlling the hardware threads of one processor core. Through it the host can stop a thread, let it run again, or soft-reset it. It can also read back which threads are halted, which are quiesced, and whether the core is set up as a single partition.

Every access is a full 8-byte word at an 8-byte aligned byte address. The word offset is the byte address shifted right by three. Bits are numbered MSB-first, so bit 0 is the most significant bit of the word. Each thread owns an 8-bit lane of the command word.

A control write acts on every lane at once. For each thread it updates the held quiesced state and issues single-cycle pause, resume and soft-reset pulses, registered one clock after the write. Any access the block does not implement raises a one-cycle flag, and a read of such an access returns zero. The thread count is a parameter, up to four.

Top module: `core_runctl`

## Requirements
- R1: While reset is high, and in the first cycle after it, every thread's quiesced state is 0 and `rd_valid`, `unimp_flag` and all pulses are 0.
- R2: A read at word offset 0x412 returns the thread-state word one cycle later, with `rd_valid` high. Bit (56+i) equals thread i's halted input, bit 62 equals the partition-per-core input, and every other bit is 0.
- R3: A read at word offset 0x413 returns zero one cycle later and does not raise `unimp_flag`.
- R4: A read at word offset 0x454 returns, one cycle later, a word in which bits (8i) and (8i+1) are both set exactly when thread i is quiesced. All other bits are 0.
- R5: A write at word offset 0x449 with bit (8i+7) set and no clearing command in lane i pulses `thr_pause[i]` in the next cycle and sets thread i quiesced.
- R6: In a control write, bit (8i+6) (start) or bit (8i+3) (clear-maintenance) pulses `thr_resume[i]` in the next cycle and clears thread i's quiesced state.
- R7: In a control write, bit (8i+4) pulses `thr_sreset[i]` in the next cycle and clears thread i's quiesced state.
- R8: Commands within one lane apply in the order stop, start, soft-reset, clear-maintenance. When stop is combined with any clearing command, the thread ends not quiesced, and the pause pulse and the other pulses all occur in the same cycle.
- R9: A control write raises `unimp_flag` in the next cycle when any bit set in it is not a recognised command bit of a thread below `NUM_THREADS`. Lanes of threads at or above `NUM_THREADS` have no effect.
- R10: A read or write at any other word offset, a write to 0x412, 0x413 or 0x454, and a read of 0x449 all raise `unimp_flag` in the next cycle. Such a read returns zero, and none of these accesses changes any quiesced state or pulses any thread.
- R11: An access whose size is not 8 bytes, or whose byte address is not 8-byte aligned, raises `unimp_flag`, returns zero on a read and has no effect on any thread.
- R12: Pulses and `unimp_flag` last one cycle: with no access in a cycle, all of them are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address |
| acc_size | input | 4 | Access size in bytes; only 8 is valid |
| acc_wdata | input | 64 | Write data, bit 0 is the MSB |
| thr_halted | input | NUM_THREADS | Per-thread halted status |
| cfg_lpar_per_core | input | 1 | Partition-per-core configuration |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 64 | Read data |
| unimp_flag | output | 1 | One-cycle flag for an unimplemented access or bits |
| thr_quiesced | output | NUM_THREADS | Held quiesced state per thread |
| thr_pause | output | NUM_THREADS | One-cycle pause pulse per thread |
| thr_resume | output | NUM_THREADS | One-cycle resume pulse per thread |
| thr_sreset | output | NUM_THREADS | One-cycle soft-reset pulse per thread |

## Verification
The bench aims at the lane bit positions under MSB-first numbering. A design that counted bits from the LSB would pulse the wrong thread, or flag a valid command as stray bits.

It combines stop with each clearing command in one lane. A design that applied the commands in the wrong order would leave the thread quiesced.

It writes commands into the lane of a thread beyond the configured count, and it sends wrong-size or misaligned writes that carry valid commands. A design that ignored either case would change a thread's quiesced state or fail to raise the flag.

It also sends reads and writes to the wrong register. A design that decoded only the offset and not the direction would return status for a read of the control register, or act on a write to a status register.

// File: rtl/core_runctl_pkg.sv
package core_runctl_pkg;
  localparam int WORD_W = 64;
  localparam int LANE_W = 8;
  localparam int MAX_THREADS = 4;

  // word offsets decoded by the block
  localparam int OFS_TSTATE = 'h412;
  localparam int OFS_TINFO  = 'h413;
  localparam int OFS_CTRL   = 'h449;
  localparam int OFS_RAS    = 'h454;

  // command bit positions inside a lane, MSB-first numbering
  localparam int CMD_STOP  = 7;
  localparam int CMD_START = 6;
  localparam int CMD_SRST  = 4;
  localparam int CMD_CLRM  = 3;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_TSTATE,
    ACC_TINFO,
    ACC_RAS,
    ACC_CTRL,
    ACC_BAD
  } acc_kind_e;

  // convert MSB-first bit number into a vector index
  function automatic int bitpos(input int k);
    return WORD_W - 1 - k;
  endfunction
endpackage

// File: rtl/core_runctl_decode.sv
module core_runctl_decode
  import core_runctl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  output acc_kind_e         kind
);
  localparam int OFS_W = ADDR_W - 3;

  logic [OFS_W-1:0] ofs;
  logic             shape_ok;

  assign ofs      = addr[ADDR_W-1:3];
  assign shape_ok = (size == 4'd8) && (addr[2:0] == 3'b000);

  always_comb begin
    kind = ACC_NONE;
    if (valid) begin
      if (!shape_ok) begin
        kind = ACC_BAD;
      end else if (write) begin
        kind = (ofs == OFS_W'(OFS_CTRL)) ? ACC_CTRL : ACC_BAD;
      end else if (ofs == OFS_W'(OFS_TSTATE)) begin
        kind = ACC_TSTATE;
      end else if (ofs == OFS_W'(OFS_TINFO)) begin
        kind = ACC_TINFO;
      end else if (ofs == OFS_W'(OFS_RAS)) begin
        kind = ACC_RAS;
      end else begin
        kind = ACC_BAD;
      end
    end
  end
endmodule

// File: rtl/core_runctl_lane.sv
module core_runctl_lane (
  input  logic clk,
  input  logic rst,
  input  logic cmd_en,
  input  logic cmd_stop,
  input  logic cmd_start,
  input  logic cmd_srst,
  input  logic cmd_clrm,
  output logic quiesced,
  output logic pause_p,
  output logic resume_p,
  output logic sreset_p
);
  logic clr_any;
  assign clr_any = cmd_start | cmd_srst | cmd_clrm;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiesced <= 1'b0;
      pause_p  <= 1'b0;
      resume_p <= 1'b0;
      sreset_p <= 1'b0;
    end else begin
      pause_p  <= cmd_en & cmd_stop;
      resume_p <= cmd_en & (cmd_start | cmd_clrm);
      sreset_p <= cmd_en & cmd_srst;
      if (cmd_en) begin
        // later commands override stop
        if (clr_any)       quiesced <= 1'b0;
        else if (cmd_stop) quiesced <= 1'b1;
      end
    end
  end

  AST_STOP_QUIESCES: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && cmd_stop && !clr_any) |=> quiesced); // R5
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && clr_any) |=> !quiesced); // R8
  AST_QUIESCE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cmd_en |=> $stable(quiesced)); // R10
endmodule

// File: rtl/core_runctl_status.sv
module core_runctl_status
  import core_runctl_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic [NUM_THREADS-1:0] halted,
  input  logic                   lpar,
  input  logic [NUM_THREADS-1:0] quiesced,
  input  logic [WORD_W-1:0]      wdata,
  output logic [WORD_W-1:0]      tstate_word,
  output logic [WORD_W-1:0]      ras_word,
  output logic                   resid_nz
);
  logic [WORD_W-1:0] known_mask;

  always_comb begin
    tstate_word = '0;
    ras_word    = '0;
    known_mask  = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      tstate_word[bitpos(56 + i)] = halted[i];
      ras_word[bitpos(LANE_W*i)]     = quiesced[i];
      ras_word[bitpos(LANE_W*i + 1)] = quiesced[i];
      known_mask[bitpos(LANE_W*i + CMD_STOP)]  = 1'b1;
      known_mask[bitpos(LANE_W*i + CMD_START)] = 1'b1;
      known_mask[bitpos(LANE_W*i + CMD_SRST)]  = 1'b1;
      known_mask[bitpos(LANE_W*i + CMD_CLRM)]  = 1'b1;
    end
    tstate_word[bitpos(62)] = lpar;
  end

  assign resid_nz = |(wdata & ~known_mask);
endmodule

// File: rtl/core_runctl.sv
module core_runctl
  import core_runctl_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int ADDR_W      = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   acc_valid,
  input  logic                   acc_write,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic [3:0]             acc_size,
  input  logic [63:0]            acc_wdata,
  input  logic [NUM_THREADS-1:0] thr_halted,
  input  logic                   cfg_lpar_per_core,
  output logic                   rd_valid,
  output logic [63:0]            rd_data,
  output logic                   unimp_flag,
  output logic [NUM_THREADS-1:0] thr_quiesced,
  output logic [NUM_THREADS-1:0] thr_pause,
  output logic [NUM_THREADS-1:0] thr_resume,
  output logic [NUM_THREADS-1:0] thr_sreset
);
  acc_kind_e         kind;
  logic              ctrl_en;
  logic [WORD_W-1:0] tstate_word;
  logic [WORD_W-1:0] ras_word;
  logic              resid_nz;

  core_runctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .valid (acc_valid),
    .write (acc_write),
    .addr  (acc_addr),
    .size  (acc_size),
    .kind  (kind)
  );

  assign ctrl_en = (kind == ACC_CTRL);

  core_runctl_status #(.NUM_THREADS(NUM_THREADS)) u_status (
    .halted      (thr_halted),
    .lpar        (cfg_lpar_per_core),
    .quiesced    (thr_quiesced),
    .wdata       (acc_wdata),
    .tstate_word (tstate_word),
    .ras_word    (ras_word),
    .resid_nz    (resid_nz)
  );

  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_lane
    core_runctl_lane u_lane (
      .clk       (clk),
      .rst       (rst),
      .cmd_en    (ctrl_en),
      .cmd_stop  (acc_wdata[bitpos(LANE_W*i + CMD_STOP)]),
      .cmd_start (acc_wdata[bitpos(LANE_W*i + CMD_START)]),
      .cmd_srst  (acc_wdata[bitpos(LANE_W*i + CMD_SRST)]),
      .cmd_clrm  (acc_wdata[bitpos(LANE_W*i + CMD_CLRM)]),
      .quiesced  (thr_quiesced[i]),
      .pause_p   (thr_pause[i]),
      .resume_p  (thr_resume[i]),
      .sreset_p  (thr_sreset[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      unimp_flag <= 1'b0;
    end else begin
      rd_valid   <= acc_valid & ~acc_write;
      unimp_flag <= (kind == ACC_BAD) | (ctrl_en & resid_nz);
      case (kind)
        ACC_TSTATE: rd_data <= tstate_word;
        ACC_RAS:    rd_data <= ras_word;
        default:    rd_data <= '0;
      endcase
    end
  end

  AST_RDV_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_valid && !acc_write)); // R2
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    !$past(acc_valid) |-> (thr_pause == '0 && thr_resume == '0 &&
                           thr_sreset == '0 && !unimp_flag)); // R12
  AST_PAUSE_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    (thr_pause != '0) |-> $past(acc_valid && acc_write)); // R5
endmodule

// File: tb/core_runctl_bench.sv
module core_runctl_bench;
  localparam int NT = 3;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          acc_valid, acc_write;
  logic [AW-1:0] acc_addr;
  logic [3:0]    acc_size;
  logic [63:0]   acc_wdata;
  logic [NT-1:0] thr_halted;
  logic          cfg_lpar;
  logic          rd_valid, unimp_flag;
  logic [63:0]   rd_data;
  logic [NT-1:0] thr_quiesced, thr_pause, thr_resume, thr_sreset;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  finished = 0;

  logic [NT-1:0] m_q;

  always #10 clk = ~clk;

  core_runctl #(.NUM_THREADS(NT), .ADDR_W(AW)) u_core_runctl (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .thr_halted(thr_halted), .cfg_lpar_per_core(cfg_lpar),
    .rd_valid(rd_valid), .rd_data(rd_data), .unimp_flag(unimp_flag),
    .thr_quiesced(thr_quiesced), .thr_pause(thr_pause),
    .thr_resume(thr_resume), .thr_sreset(thr_sreset)
  );

  function automatic int bp(input int k);
    return 63 - k;
  endfunction

  function automatic logic [63:0] cmdbits(input int lane, input logic stop,
      input logic start, input logic srst, input logic clrm);
    logic [63:0] w = '0;
    w[bp(8*lane+7)] = stop;
    w[bp(8*lane+6)] = start;
    w[bp(8*lane+4)] = srst;
    w[bp(8*lane+3)] = clrm;
    return w;
  endfunction

  function automatic logic [63:0] exp_tstate(input logic [NT-1:0] h, input logic lp);
    logic [63:0] w = '0;
    for (int i = 0; i < NT; i++) w[bp(56+i)] = h[i];
    w[bp(62)] = lp;
    return w;
  endfunction

  function automatic logic [63:0] exp_ras(input logic [NT-1:0] q);
    logic [63:0] w = '0;
    for (int i = 0; i < NT; i++) begin
      w[bp(8*i)] = q[i];
      w[bp(8*i+1)] = q[i];
    end
    return w;
  endfunction

  task automatic compare(input string req, input logic e_rdv, input logic [63:0] e_rd,
      input logic e_flag, input logic [NT-1:0] e_p, input logic [NT-1:0] e_r,
      input logic [NT-1:0] e_s);
    n_checks++;
    if (rd_valid !== e_rdv || (e_rdv && rd_data !== e_rd) || unimp_flag !== e_flag ||
        thr_pause !== e_p || thr_resume !== e_r || thr_sreset !== e_s ||
        thr_quiesced !== m_q) begin
      n_fail++;
      $display("FAIL %s: got rdv=%b rd=%h flag=%b p=%b r=%b s=%b q=%b exp rdv=%b rd=%h flag=%b p=%b r=%b s=%b q=%b",
               req, rd_valid, rd_data, unimp_flag, thr_pause, thr_resume, thr_sreset,
               thr_quiesced, e_rdv, e_rd, e_flag, e_p, e_r, e_s, m_q);
    end
  endtask

  task automatic access(input logic wr, input int ofs, input logic [3:0] sz,
      input logic [2:0] low, input logic [63:0] wd);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_write = wr;
    acc_addr  = AW'(ofs) << 3 | AW'(low);
    acc_size  = sz;
    acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // control write with model update and check
  task automatic ctrl_write(input string req, input logic [63:0] wd,
      input logic [3:0] sz, input logic [2:0] low);
    logic [NT-1:0] p = '0, r = '0, s = '0;
    logic [63:0] known = '0;
    logic ok = (sz == 4'd8) && (low == 3'd0);
    for (int i = 0; i < NT; i++) known |= cmdbits(i, 1, 1, 1, 1);
    access(1'b1, 'h449, sz, low, wd);
    if (ok) begin
      for (int i = 0; i < NT; i++) begin
        p[i] = wd[bp(8*i+7)];
        r[i] = wd[bp(8*i+6)] | wd[bp(8*i+3)];
        s[i] = wd[bp(8*i+4)];
        if (r[i] | s[i]) m_q[i] = 1'b0;
        else if (p[i]) m_q[i] = 1'b1;
      end
    end
    compare(req, 1'b0, '0, !ok || ((wd & ~known) != 0), p, r, s);
  endtask

  task automatic read_chk(input string req, input int ofs, input logic [3:0] sz,
      input logic [2:0] low);
    logic [63:0] e = '0;
    logic f = 1'b0;
    logic ok = (sz == 4'd8) && (low == 3'd0);
    access(1'b0, ofs, sz, low, '0);
    if (!ok) f = 1'b1;
    else if (ofs == 'h412) e = exp_tstate(thr_halted, cfg_lpar);
    else if (ofs == 'h454) e = exp_ras(m_q);
    else if (ofs != 'h413) f = 1'b1;
    compare(req, 1'b1, e, f, '0, '0, '0);
  endtask

  task automatic idle_chk(input string req);
    @(negedge clk);
    compare(req, 1'b0, '0, 1'b0, '0, '0, '0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst = 1'b1; acc_valid = 0; acc_write = 0; acc_addr = '0; acc_size = 4'd8;
    acc_wdata = '0; thr_halted = '0; cfg_lpar = 0; m_q = '0;
    repeat (3) @(negedge clk);
    compare("R1 in reset", 1'b0, '0, 1'b0, '0, '0, '0);
    rst = 1'b0;
    idle_chk("R1 after reset");

    thr_halted = 3'b101; cfg_lpar = 1;
    read_chk("R2 thread state", 'h412, 4'd8, 3'd0);
    thr_halted = 3'b010; cfg_lpar = 0;
    read_chk("R2 thread state b", 'h412, 4'd8, 3'd0);
    read_chk("R3 info zero", 'h413, 4'd8, 3'd0);
    ctrl_write("R5 stop lane0", cmdbits(0, 1, 0, 0, 0), 4'd8, 3'd0);
    idle_chk("R12 pulse ends");
    read_chk("R4 ras one quiesced", 'h454, 4'd8, 3'd0);
    ctrl_write("R5 stop lane2", cmdbits(2, 1, 0, 0, 0), 4'd8, 3'd0);
    ctrl_write("R6 start lane0", cmdbits(0, 0, 1, 0, 0), 4'd8, 3'd0);
    ctrl_write("R6 clear maint lane2", cmdbits(2, 0, 0, 0, 1), 4'd8, 3'd0);
    ctrl_write("R5 stop lane1", cmdbits(1, 1, 0, 0, 0), 4'd8, 3'd0);
    ctrl_write("R7 sreset lane1", cmdbits(1, 0, 0, 1, 0), 4'd8, 3'd0);
    ctrl_write("R8 stop+start lane1", cmdbits(1, 1, 1, 0, 0), 4'd8, 3'd0);
    ctrl_write("R8 stop+sreset lane0", cmdbits(0, 1, 0, 1, 0), 4'd8, 3'd0);
    ctrl_write("R8 stop+clrm lane2", cmdbits(2, 1, 0, 0, 1), 4'd8, 3'd0);
    ctrl_write("R5 stop all", cmdbits(0,1,0,0,0) | cmdbits(1,1,0,0,0) | cmdbits(2,1,0,0,0), 4'd8, 3'd0);
    ctrl_write("R9 lane beyond count", cmdbits(3, 0, 1, 0, 0), 4'd8, 3'd0);
    ctrl_write("R9 stray bit", cmdbits(0, 0, 1, 0, 0) | 64'h1, 4'd8, 3'd0);
    read_chk("R4 ras after mix", 'h454, 4'd8, 3'd0);
    access(1'b1, 'h412, 4'd8, 3'd0, cmdbits(1, 0, 1, 0, 0));
    compare("R10 write to status", 1'b0, '0, 1'b1, '0, '0, '0);
    read_chk("R10 read ctrl", 'h449, 4'd8, 3'd0);
    read_chk("R10 read other", 'h500, 4'd8, 3'd0);
    ctrl_write("R11 short write", cmdbits(1, 0, 1, 0, 0), 4'd4, 3'd0);
    ctrl_write("R11 misaligned write", cmdbits(2, 0, 1, 0, 0), 4'd8, 3'd4);
    read_chk("R11 short read", 'h412, 4'd4, 3'd0);

    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      thr_halted = NT'($urandom);
      cfg_lpar = 1'($urandom);
      if (op < 5) begin
        logic [63:0] w = '0;
        for (int i = 0; i < 4; i++)
          w |= cmdbits(i, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        w &= {$urandom, $urandom} | {$urandom, $urandom};
        if ($urandom_range(0, 3) == 0) w |= 64'h1 << $urandom_range(0, 63);
        ctrl_write("R8 random control", w, ($urandom_range(0, 15) == 0) ? 4'd2 : 4'd8, 3'd0);
      end else if (op == 5) read_chk("R2 random tstate", 'h412, 4'd8, 3'd0);
      else if (op == 6) read_chk("R4 random ras", 'h454, 4'd8, 3'd0);
      else if (op == 7) read_chk("R3 random info", 'h413, 4'd8, 3'd0);
      else if (op == 8) read_chk("R10 random bad read", $urandom_range(0, 'hfff) | 'h1000, 4'd8, 3'd0);
      else idle_chk("R12 random idle");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule